// File: doc/BRIEF.md
# I2C Command-Driven Block Transfer Engine

This block is the bus-facing engine of an I2C host controller. One command word starts one transfer. The transfer is either a block write or a block read. The engine first pulls the target address byte from a byte source. On a write it then keeps pulling data bytes until a byte marked as final has gone out. On a read it collects a programmed number of bytes and pushes them into a sink. At the end it issues a STOP, drops its busy flag and leaves a 3-bit completion code.

SCL and SDA are open drain. For each line the engine has an output enable that pulls the line low, and it reads the line level back on a separate input. The SCL low and high phases are each a fixed number of system clocks. A mode input picks the standard (100 kHz) count or the fast (400 kHz) count. A target may stretch the clock by holding SCL low, and the engine waits for it. If SCL stays low too long, the engine gives up and reports a timeout. The engine also reports lost arbitration, an address NACK, a data NACK, a byte source that runs dry, and a sink that is full.

Top module: `i2c_cmd_engine`

## Requirements
- R1: After reset the engine shows busy=0 and status=0. Both output enables are 0, tx_ready=0 and rx_valid=0.
- R2: A command write starts a transfer only when all of these hold: bit 31 is 1, the engine is idle, and bits 12:9 hold 7 (block write) or 8 (block read). For a read, bits 7:0 must also be nonzero. busy is 1 from the next cycle. A command that fails any of these is ignored: busy stays 0 and no byte is taken from the source.
- R3: A block write sends each byte MSB first, followed by an ACK slot. The first byte sent is the first source byte, which is the address with R/W in bit 0. A STOP follows the byte that carried tx_last=1, and status ends as 0.
- R4: A block read takes only the address byte from the source. It then receives the count given in bits 7:0. Each byte appears on rx_data with a one-cycle rx_valid pulse. Every byte is ACKed except the last, which is NACKed before the STOP.
- R5: When a transfer ends, busy falls and status takes its code in the same cycle. The codes are 0 success, 1 lost arbitration, 2 address NACK, 3 data NACK, 4 timeout, 5 source underrun and 6 sink full. status does not change while busy stays 1.
- R6: If the address byte is NACKed, a STOP is issued and status becomes 2. No further source byte is taken.
- R7: If a data byte is NACKed on a write, a STOP is issued and status becomes 3.
- R8: If a byte is needed on a write but tx_valid is 0, a STOP is issued and status becomes 5. tx_ready is only asserted together with tx_valid.
- R9: If rx_full is 1 when a read byte completes, the byte is dropped and NACKed, a STOP follows, and status becomes 6.
- R10: If the engine releases SDA during a transmitted bit but samples it low, it releases both lines at once. It then ends with status 1 and sends no STOP.
- R11: With no stretching, SCL rising edges inside a byte are 2*DIV_STD clocks apart in standard mode and 2*DIV_FAST clocks apart in fast mode. A high phase does not start counting while scl_in is held low.
- R12: If scl_in stays low for TIMEOUT_CYC clocks during a released phase, the engine releases the bus and ends with status 4.
- R13: While cfg_reset=1 or cfg_enable=0, the engine is held idle. busy and status are cleared, both lines are released, and commands are ignored.
- R14: A command written while busy=1 is ignored. The running transfer finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_reset | input | 1 | Holds the engine idle when 1 |
| cfg_enable | input | 1 | Engine runs only when 1 |
| fast_mode | input | 1 | 1 selects fast-mode phase length, 0 standard |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word: start 31, protocol 12:9, read count 7:0 |
| busy | output | 1 | Transfer in progress |
| status | output | 3 | Completion code of the last transfer |
| tx_valid | input | 1 | Byte source has a byte |
| tx_data | input | 8 | Source byte |
| tx_last | input | 1 | Source byte is the last of a write |
| tx_ready | output | 1 | Source byte taken this cycle |
| rx_valid | output | 1 | Received byte strobe |
| rx_data | output | 8 | Received byte |
| rx_full | input | 1 | Sink cannot accept a byte |
| scl_oe | output | 1 | Pull SCL low |
| scl_in | input | 1 | Sampled SCL level |
| sda_oe | output | 1 | Pull SDA low |
| sda_in | input | 1 | Sampled SDA level |

## Verification
The bench attaches a behavioural target that can ACK or NACK any chosen byte, stretch the clock, or hold SCL down indefinitely. A second driver can pin SDA low to force lost arbitration.
- A final read byte that gets an ACK instead of a NACK shows up in the target's ACK tally.
- A design that checks the sink too late would pass a byte through when rx_full is set.
- A design that fetches before testing tx_valid would show up as a wrong underrun code or a wrong count of bytes taken.
- Phase counters that are off by one show up in the measured SCL period.
- A design that ignores stretching shows up as a short low run.
- Commands written while busy or while disabled, or carrying an illegal protocol or a zero read count, must leave busy and the byte source untouched.

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine #(
  parameter int DIV_STD     = 250,
  parameter int DIV_FAST    = 63,
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_reset,
  input  logic        cfg_enable,
  input  logic        fast_mode,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  output logic        busy,
  output logic [2:0]  status,
  input  logic        tx_valid,
  input  logic [7:0]  tx_data,
  input  logic        tx_last,
  output logic        tx_ready,
  output logic        rx_valid,
  output logic [7:0]  rx_data,
  input  logic        rx_full,
  output logic        scl_oe,
  input  logic        scl_in,
  output logic        sda_oe,
  input  logic        sda_in
);
  localparam int DMAX = (DIV_STD > DIV_FAST) ? DIV_STD : DIV_FAST;
  localparam int DW   = $clog2(DMAX) + 1;
  localparam int TW   = $clog2(TIMEOUT_CYC + 1) + 1;
  localparam logic [3:0] PROTO_WR = 4'd7;
  localparam logic [3:0] PROTO_RD = 4'd8;
  localparam logic [2:0] ST_OK = 3'd0, ST_ARB = 3'd1, ST_NADDR = 3'd2, ST_NDATA = 3'd3,
                         ST_TMO = 3'd4, ST_UNDER = 3'd5, ST_RXFULL = 3'd6;

  typedef enum logic [2:0] {IDLE, START, LOAD, BLO, BHI, PLO, PHI, PEND} state_t;

  state_t        st;
  logic [DW-1:0] cnt;
  logic [TW-1:0] tcnt;
  logic [7:0]    sh;
  logic [3:0]    bidx;
  logic [7:0]    remain;
  logic [2:0]    err;
  logic          is_rd, addr_ph, last_q, sda_q;

  logic [DW-1:0] half_m1;
  logic          en, tx_mode, phase_end, go, bit_drive, unused_cmd;
  logic [3:0]    proto;
  logic [7:0]    byte_in;

  assign half_m1    = fast_mode ? DW'(DIV_FAST - 1) : DW'(DIV_STD - 1);
  assign en         = cfg_enable & ~cfg_reset;
  assign tx_mode    = ~is_rd | addr_ph;
  assign phase_end  = (cnt == half_m1);
  assign proto      = cmd_wdata[12:9];
  assign go         = cmd_wr & cmd_wdata[31] &
                      ((proto == PROTO_WR) | ((proto == PROTO_RD) & (cmd_wdata[7:0] != 8'd0)));
  assign byte_in    = {sh[6:0], sda_in};
  assign unused_cmd = ^{cmd_wdata[30:13], cmd_wdata[8]};

  always_comb begin
    if (bidx != 4'd8) bit_drive = tx_mode & ~sh[7];
    else              bit_drive = ~tx_mode & (remain != 8'd1) & (err == ST_OK);
  end

  assign scl_oe   = (st == BLO) | (st == PLO);
  assign sda_oe   = sda_q;
  assign tx_ready = (st == LOAD) & tx_mode & tx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; tcnt <= '0; sh <= '0; bidx <= '0; remain <= '0;
      err <= ST_OK; is_rd <= 1'b0; addr_ph <= 1'b0; last_q <= 1'b0; sda_q <= 1'b0;
      busy <= 1'b0; status <= ST_OK; rx_valid <= 1'b0; rx_data <= '0;
    end else if (!en) begin
      st <= IDLE; cnt <= '0; tcnt <= '0; sh <= '0; bidx <= '0; remain <= '0;
      err <= ST_OK; is_rd <= 1'b0; addr_ph <= 1'b0; last_q <= 1'b0; sda_q <= 1'b0;
      busy <= 1'b0; status <= ST_OK; rx_valid <= 1'b0; rx_data <= '0;
    end else begin
      rx_valid <= 1'b0;
      case (st)
        IDLE: if (go) begin
          busy <= 1'b1; status <= ST_OK; err <= ST_OK;
          is_rd <= (proto == PROTO_RD); remain <= cmd_wdata[7:0];
          addr_ph <= 1'b1; cnt <= '0; sda_q <= 1'b1; st <= START;
        end
        START: begin
          cnt <= cnt + 1'b1;
          if (phase_end) begin cnt <= '0; st <= LOAD; end
        end
        LOAD: begin
          bidx <= '0; cnt <= '0;
          if (!tx_mode) st <= BLO;
          else if (tx_valid) begin sh <= tx_data; last_q <= tx_last; st <= BLO; end
          else begin err <= ST_UNDER; st <= PLO; end
        end
        BLO: begin
          cnt <= cnt + 1'b1;
          if (cnt == '0) sda_q <= bit_drive;
          if (phase_end) begin cnt <= '0; tcnt <= '0; st <= BHI; end
        end
        BHI, PHI: begin
          if (!scl_in) begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == TW'(TIMEOUT_CYC - 1)) begin
              status <= ST_TMO; busy <= 1'b0; sda_q <= 1'b0; st <= IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
            if (phase_end) begin
              cnt <= '0;
              if (st == PHI) begin
                sda_q <= 1'b0; st <= PEND;
              end else if (bidx != 4'd8) begin
                if (tx_mode & ~sda_q & ~sda_in) begin
                  status <= ST_ARB; busy <= 1'b0; st <= IDLE;
                end else begin
                  sh <= byte_in; bidx <= bidx + 1'b1; st <= BLO;
                  if (!tx_mode && bidx == 4'd7) begin
                    if (rx_full) err <= ST_RXFULL;
                    else begin rx_valid <= 1'b1; rx_data <= byte_in; end
                  end
                end
              end else if (tx_mode) begin
                if (sda_in) begin
                  err <= addr_ph ? ST_NADDR : ST_NDATA; st <= PLO;
                end else begin
                  addr_ph <= 1'b0;
                  st <= (~is_rd & last_q) ? PLO : LOAD;
                end
              end else begin
                remain <= remain - 1'b1;
                st <= ((remain == 8'd1) || (err != ST_OK)) ? PLO : LOAD;
              end
            end
          end
        end
        PLO: begin
          cnt <= cnt + 1'b1;
          if (cnt == '0) sda_q <= 1'b1;
          if (phase_end) begin cnt <= '0; tcnt <= '0; st <= PHI; end
        end
        PEND: begin
          cnt <= cnt + 1'b1;
          if (phase_end) begin busy <= 1'b0; status <= err; st <= IDLE; end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_cmd_engine_chk.sv
module i2c_cmd_engine_chk #(
  parameter int TIMEOUT_CYC = 100000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_reset,
  input logic        cfg_enable,
  input logic        cmd_wr,
  input logic [31:0] cmd_wdata,
  input logic        busy,
  input logic [2:0]  status,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        rx_valid,
  input logic        scl_oe,
  input logic        scl_in,
  input logic        sda_oe
);
  int lowrun;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lowrun <= 0;
    else if (busy && !scl_oe && !scl_in) lowrun <= lowrun + 1;
    else lowrun <= 0;
  end

  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  // R13
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_reset || !cfg_enable) |=> !busy);

  // R2
  bad_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_wr && !cmd_wdata[31]) |=> !busy);

  // R5
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(status)));

  // R8
  tx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (tx_valid && busy));

  // R4
  rx_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> busy);

  // R12
  stretch_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lowrun <= TIMEOUT_CYC);
endmodule

bind i2c_cmd_engine i2c_cmd_engine_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_reset(cfg_reset), .cfg_enable(cfg_enable),
  .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .busy(busy), .status(status),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .scl_oe(scl_oe), .scl_in(scl_in), .sda_oe(sda_oe));

// File: tb/sim_i2c_cmd_engine.sv
`timescale 1ns/1ps
module sim_i2c_cmd_engine;
  localparam int DS = 20, DF = 5, TMO = 300;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic cfg_reset = 0, cfg_enable = 1, fast_mode = 0, cmd_wr = 0, rx_full = 0;
  logic [31:0] cmd_wdata = 0;
  logic busy, tx_ready, rx_valid, scl_oe, sda_oe, tx_valid, tx_last;
  logic [2:0] status;
  logic [7:0] rx_data, tx_data;
  logic scl_l, sda_l, s_sda = 0, jam = 0, clr = 0, mark_last = 1;
  int hold_cnt = 0;

  logic [7:0] tx_q [0:15];
  int tx_n = 0, tx_rd = 0;
  assign tx_valid = tx_rd < tx_n;
  assign tx_data  = tx_q[tx_rd[3:0]];
  assign tx_last  = mark_last && (tx_rd == tx_n - 1);
  assign scl_l = ~scl_oe & (hold_cnt == 0);
  assign sda_l = ~sda_oe & ~s_sda & ~jam;

  i2c_cmd_engine #(.DIV_STD(DS), .DIV_FAST(DF), .TIMEOUT_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_reset(cfg_reset), .cfg_enable(cfg_enable),
    .fast_mode(fast_mode), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .busy(busy),
    .status(status), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .rx_full(rx_full),
    .scl_oe(scl_oe), .scl_in(scl_l), .sda_oe(sda_oe), .sda_in(sda_l));

  logic [7:0] rx_got [0:15];
  int n_got = 0;
  always @(posedge clk) begin
    if (clr) begin tx_rd <= 0; n_got <= 0; end
    else begin
      if (tx_ready) tx_rd <= tx_rd + 1;
      if (rx_valid) begin rx_got[n_got[3:0]] <= rx_data; n_got <= n_got + 1; end
    end
  end

  // behavioural target at address 0x50
  logic [7:0] slog [0:15];
  logic [7:0] ssh, rd_base = 8'hC3;
  logic p_scl = 1, p_sda = 1, active = 0, sending = 0, m_ack = 0, addr_ok = 0, rw = 0;
  int bitcnt = 0, n = 0, k = 0, nack_at = 99, stretch_n = 0, stops = 0;
  int m_ack_n = 0, m_nack_n = 0, cyc = 0, last_rise = -1, min_per = 1000000;
  int lowrun = 0, max_low = 0;
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (hold_cnt > 0) hold_cnt = hold_cnt - 1;
    if (clr) begin
      active = 0; sending = 0; s_sda = 0; hold_cnt = 0; n = 0; stops = 0; bitcnt = 0;
      m_ack_n = 0; m_nack_n = 0; last_rise = -1; min_per = 1000000; max_low = 0; lowrun = 0;
    end else begin
      if (!p_scl && scl_l) begin
        if (last_rise >= 0 && cyc - last_rise < min_per) min_per = cyc - last_rise;
        last_rise = cyc;
      end
      if (!scl_l) lowrun = lowrun + 1;
      else begin if (lowrun > max_low) max_low = lowrun; lowrun = 0; end
      if (p_scl && scl_l && p_sda && !sda_l) begin
        active = 1; sending = 0; bitcnt = 0; n = 0; k = 0;
      end else if (p_scl && scl_l && !p_sda && sda_l) begin
        active = 0; s_sda = 0; stops = stops + 1;
      end else if (active) begin
        if (!p_scl && scl_l) begin
          if (bitcnt < 8 && !sending) ssh = {ssh[6:0], sda_l};
          if (bitcnt == 8 && sending) begin
            m_ack = !sda_l;
            if (m_ack) m_ack_n = m_ack_n + 1; else m_nack_n = m_nack_n + 1;
          end
          bitcnt = bitcnt + 1;
        end else if (p_scl && !scl_l) begin
          if (bitcnt == 8) begin
            if (!sending) begin
              slog[n[3:0]] = ssh;
              if (n == 0) begin addr_ok = (ssh[7:1] == 7'h50); rw = ssh[0]; s_sda = addr_ok; end
              else s_sda = (n != nack_at);
              n = n + 1;
              if (stretch_n > 0) hold_cnt = stretch_n;
            end else s_sda = 0;
          end else if (bitcnt == 9) begin
            bitcnt = 0; s_sda = 0;
            if (!addr_ok) active = 0;
            else if (!sending && n == 1 && rw) begin sending = 1; m_ack = 1; end
            if (active && sending) begin
              if (m_ack) begin ssh = rd_base + 8'(k); k = k + 1; s_sda = !ssh[7]; end
              else active = 0;
            end
          end else if (sending && bitcnt >= 1 && bitcnt <= 7) s_sda = !ssh[7 - bitcnt];
        end
      end
    end
    p_scl = scl_l; p_sda = sda_l;
  end

  int vec = 0, bad = 0;
  task automatic chk(string tag, int act, int exp);
    vec = vec + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  function automatic logic [31:0] mk(int p, int c);
    return 32'h8000_0000 | (32'(p) << 9) | 32'(c);
  endfunction

  task automatic prep();
    @(negedge clk); clr = 1; jam = 0; rx_full = 0; nack_at = 99; stretch_n = 0;
    mark_last = 1; tx_n = 0; fast_mode = 0;
    @(negedge clk); @(negedge clk); clr = 0;
  endtask

  task automatic launch(logic [31:0] w);
    @(negedge clk); cmd_wr = 1; cmd_wdata = w;
    @(negedge clk); cmd_wr = 0; cmd_wdata = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    if (busy) chk("transfer hung", 1, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0); chk("R1 status", status, 0);
    chk("R1 scl_oe", scl_oe, 0); chk("R1 sda_oe", sda_oe, 0);
    chk("R1 tx_ready", tx_ready, 0); chk("R1 rx_valid", rx_valid, 0);
  endtask

  task automatic t_write_std();
    prep(); tx_q[0] = 8'hA0; tx_q[1] = 8'h11; tx_q[2] = 8'h22; tx_q[3] = 8'h93; tx_n = 4;
    launch(mk(7, 0)); chk("R2 busy after launch", busy, 1); wait_done();
    chk("R3 status", status, 0); chk("R3 bytes seen", n, 4);
    chk("R3 byte0", slog[0], 8'hA0); chk("R3 byte1", slog[1], 8'h11);
    chk("R3 byte3", slog[3], 8'h93); chk("R3 stop", stops, 1);
    chk("R11 std period", min_per, 2 * DS);
  endtask

  task automatic t_write_fast();
    prep(); fast_mode = 1; tx_q[0] = 8'hA0; tx_q[1] = 8'h5A; tx_n = 2;
    launch(mk(7, 0)); wait_done();
    chk("R11 fast status", status, 0); chk("R11 fast byte", slog[1], 8'h5A);
    chk("R11 fast period", min_per, 2 * DF);
  endtask

  task automatic t_read();
    prep(); tx_q[0] = 8'hA1; tx_n = 1;
    launch(mk(8, 3)); wait_done();
    chk("R4 status", status, 0); chk("R4 count", n_got, 3);
    chk("R4 b0", rx_got[0], 8'hC3); chk("R4 b1", rx_got[1], 8'hC4); chk("R4 b2", rx_got[2], 8'hC5);
    chk("R4 acks", m_ack_n, 2); chk("R4 nacks", m_nack_n, 1); chk("R4 stop", stops, 1);
  endtask

  task automatic t_addr_nack();
    prep(); tx_q[0] = 8'hB0; tx_q[1] = 8'h11; tx_n = 2;
    launch(mk(7, 0)); wait_done();
    chk("R6 status", status, 2); chk("R6 taken", tx_rd, 1); chk("R6 stop", stops, 1);
  endtask

  task automatic t_data_nack();
    prep(); nack_at = 2;
    tx_q[0] = 8'hA0; tx_q[1] = 8'h01; tx_q[2] = 8'h02; tx_q[3] = 8'h03; tx_n = 4;
    launch(mk(7, 0)); wait_done();
    chk("R7 status", status, 3); chk("R7 taken", tx_rd, 3); chk("R7 stop", stops, 1);
  endtask

  task automatic t_underrun();
    prep(); mark_last = 0; tx_q[0] = 8'hA0; tx_q[1] = 8'h44; tx_n = 2;
    launch(mk(7, 0)); wait_done();
    chk("R8 status", status, 5); chk("R8 bytes seen", n, 2); chk("R8 stop", stops, 1);
  endtask

  task automatic t_rxfull();
    prep(); rx_full = 1; tx_q[0] = 8'hA1; tx_n = 1;
    launch(mk(8, 2)); wait_done();
    chk("R9 status", status, 6); chk("R9 delivered", n_got, 0);
    chk("R9 nack", m_nack_n, 1); chk("R9 stop", stops, 1);
  endtask

  task automatic t_arb();
    prep(); tx_q[0] = 8'hA0; tx_q[1] = 8'h11; tx_n = 2;
    launch(mk(7, 0)); jam = 1; wait_done();
    chk("R10 status", status, 1); chk("R10 scl released", scl_oe, 0);
    chk("R10 sda released", sda_oe, 0); chk("R10 no data byte", tx_rd, 1);
    jam = 0;
  endtask

  task automatic t_stretch();
    prep(); stretch_n = 60; tx_q[0] = 8'hA0; tx_q[1] = 8'h77; tx_n = 2;
    launch(mk(7, 0)); wait_done();
    chk("R11 stretch status", status, 0); chk("R11 stretch byte", slog[1], 8'h77);
    chk("R11 low run honoured", int'(max_low >= 60), 1);
  endtask

  task automatic t_timeout();
    prep(); stretch_n = 100000; tx_q[0] = 8'hA0; tx_q[1] = 8'h77; tx_n = 2;
    launch(mk(7, 0)); wait_done();
    chk("R12 status", status, 4); chk("R12 scl released", scl_oe, 0);
    chk("R12 sda released", sda_oe, 0);
  endtask

  task automatic t_busy_cmd();
    prep(); tx_q[0] = 8'hA0; tx_q[1] = 8'h12; tx_q[2] = 8'h34; tx_n = 3;
    launch(mk(7, 0)); repeat (10) @(negedge clk);
    launch(mk(8, 4)); chk("R14 still busy", busy, 1); wait_done();
    chk("R14 status", status, 0); chk("R14 bytes seen", n, 3);
    chk("R14 no read", n_got, 0); chk("R14 stops", stops, 1);
  endtask

  task automatic t_badcmd();
    prep(); tx_q[0] = 8'hA0; tx_n = 1;
    launch(mk(3, 0)); @(negedge clk);
    chk("R2 bad protocol busy", busy, 0); chk("R2 bad protocol taken", tx_rd, 0);
    launch(mk(8, 0)); @(negedge clk);
    chk("R2 zero count busy", busy, 0);
    launch(32'h0000_0E00 | 32'd5); @(negedge clk);
    chk("R2 no start bit busy", busy, 0); chk("R2 nothing taken", tx_rd, 0);
  endtask

  task automatic t_disable();
    prep(); tx_q[0] = 8'hA0; tx_q[1] = 8'h11; tx_n = 2;
    launch(mk(7, 0)); repeat (100) @(negedge clk);
    cfg_enable = 0; @(negedge clk);
    chk("R13 busy", busy, 0); chk("R13 scl", scl_oe, 0); chk("R13 sda", sda_oe, 0);
    launch(mk(7, 0)); chk("R13 cmd ignored", busy, 0);
    cfg_enable = 1; cfg_reset = 1; @(negedge clk);
    launch(mk(7, 0)); chk("R13 reset cmd ignored", busy, 0);
    cfg_reset = 0; @(negedge clk);
  endtask

  initial begin
    #(150000 * 5);
    chk("watchdog expired", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    t_reset();
    t_write_std();
    t_write_fast();
    t_read();
    t_addr_nack();
    t_data_nack();
    t_underrun();
    t_rxfull();
    t_arb();
    t_stretch();
    t_timeout();
    t_busy_cmd();
    t_badcmd();
    t_disable();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule